// File: doc/BRIEF.md
# Receive-Triggered Message Routing Engine

This block forwards CAN frames between the channels of a multi-channel gateway with no processor involvement. A small rule table is loaded through a write-only configuration port. Each rule holds a valid flag, the channel a frame must arrive on, an 11-bit identifier to match, a bitmask of destination channels, a 2-bit action and a replacement identifier. Merge rules also hold a byte offset and a byte count.

Each time a channel reports a new frame, the engine stores the frame and scans the table one entry per clock. The first entry that matches decides what happens. The frame can be sent on unchanged, sent under a new identifier, blocked, or have its leading bytes placed into a shared staging buffer. The staging buffer becomes a new frame once every active merge rule has contributed to it. The result is a single-cycle transmit request that carries a destination mask, an identifier and eight data bytes. The channel controllers that receive the request do the actual transmission.

Top module: `rx_route_engine`

## Requirements
- R1: After synchronous reset, `rx_busy` and `tx_valid` are low and every rule is invalid.
- R2: A frame is accepted only when `rx_valid` is high while `rx_busy` is low. `rx_busy` is high from the next cycle until the search ends, and `rx_valid` has no effect while `rx_busy` is high. A search starts only on an accepted frame.
- R3: Entries are checked in ascending index order. The lowest-index entry whose valid flag is set, whose source channel equals the frame's channel and whose identifier equals the frame's identifier is the only one acted on. Invalid entries never match.
- R4: A frame that matches no entry produces no transmit request.
- R5: Action code 0 (copy) requests transmission with the received identifier and all eight data bytes unchanged.
- R6: Action code 1 (translate) requests transmission with the entry's replacement identifier and the received data bytes unchanged.
- R7: Action code 2 (merge) writes received bytes 0 to len-1 into staging bytes offset to offset+len-1. Writes past byte 7 are dropped, and byte k sits at data bits 8k+7 to 8k. A merged frame is requested with the triggering entry's replacement identifier and the updated staging bytes once every valid merge entry has contributed since the last merged request. The contribution record is then cleared, while the staging bytes are kept.
- R8: Action code 3 (block) counts as a match, so it ends the search, but it requests nothing.
- R9: The requested destination mask is the entry's mask with the bit of the arrival channel cleared. If nothing remains, no request is made.
- R10: `tx_valid` is a one-cycle pulse. There is at most one pulse per accepted frame, and it comes at most NUM_RULES+1 cycles after acceptance, on the same edge that `rx_busy` falls.
- R11: A configuration write affects frames accepted afterwards. Writing an entry clears that entry's merge contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | $clog2(NUM_RULES) | Rule index to write |
| cfg_valid | input | 1 | Valid flag of the written rule |
| cfg_src | input | $clog2(NUM_CH) | Channel the rule listens to |
| cfg_id | input | 11 | Identifier to match |
| cfg_dest | input | NUM_CH | Destination channel mask |
| cfg_act | input | 2 | Action: 0 copy, 1 translate, 2 merge, 3 block |
| cfg_new_id | input | 11 | Replacement identifier |
| cfg_off | input | $clog2(DATA_BYTES) | Staging byte offset (merge) |
| cfg_len | input | $clog2(DATA_BYTES)+1 | Byte count (merge) |
| rx_valid | input | 1 | New frame received |
| rx_ch | input | $clog2(NUM_CH) | Arrival channel |
| rx_id | input | 11 | Received identifier |
| rx_data | input | 8*DATA_BYTES | Received data bytes |
| rx_busy | output | 1 | Search in progress; new frames refused |
| tx_valid | output | 1 | Transmit request pulse |
| tx_mask | output | NUM_CH | Channels that must send |
| tx_id | output | 11 | Identifier to send |
| tx_data | output | 8*DATA_BYTES | Data bytes to send |

## Verification
The bench loads a table of eight entries. It then sweeps every channel against a set of identifiers: some match on only one channel, one is shadowed by a blocking entry, one matches only a disabled entry, one has a mask that holds only the arrival channel, and one matches nothing. This sweep separates table-order priority, source-channel qualification and echo suppression. Merge frames are sent in different orders, with repeated contributions and with an entry rewritten halfway through. These sequences show whether the merged frame waits for every contributor and whether rewriting an entry resets its contribution. A second frame held on the receive input during a search shows whether input is refused while `rx_busy` is high.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int CAN_ID_W = 11;

  typedef enum logic [1:0] {
    ACT_COPY  = 2'd0,
    ACT_XLAT  = 2'd1,
    ACT_MERGE = 2'd2,
    ACT_BLOCK = 2'd3
  } route_act_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/route_rule_table.sv
module route_rule_table
  import route_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_RULES  = 8,
  parameter int DATA_BYTES = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int RI_W  = $clog2(NUM_RULES),
  localparam int OFF_W = $clog2(DATA_BYTES),
  localparam int LEN_W = $clog2(DATA_BYTES) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [RI_W-1:0]     wr_addr,
  input  logic                wr_valid,
  input  logic [CH_W-1:0]     wr_src,
  input  logic [CAN_ID_W-1:0] wr_id,
  input  logic [NUM_CH-1:0]   wr_dest,
  input  logic [1:0]          wr_act,
  input  logic [CAN_ID_W-1:0] wr_new_id,
  input  logic [OFF_W-1:0]    wr_off,
  input  logic [LEN_W-1:0]    wr_len,
  input  logic [RI_W-1:0]     rd_addr,
  output logic                rd_valid,
  output logic [CH_W-1:0]     rd_src,
  output logic [CAN_ID_W-1:0] rd_id,
  output logic [NUM_CH-1:0]   rd_dest,
  output logic [1:0]          rd_act,
  output logic [CAN_ID_W-1:0] rd_new_id,
  output logic [OFF_W-1:0]    rd_off,
  output logic [LEN_W-1:0]    rd_len
);
  localparam int WORD_W = CH_W + CAN_ID_W + NUM_CH + 2 + CAN_ID_W + OFF_W + LEN_W;

  // rule bodies live in a plain RAM; only the valid flags need a reset
  logic [WORD_W-1:0]    mem [NUM_RULES];
  logic [WORD_W-1:0]    rd_word;
  logic [NUM_RULES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= {wr_src, wr_id, wr_dest, wr_act, wr_new_id, wr_off, wr_len};
    end
    rd_word <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_addr] <= wr_valid;
      rd_valid <= valid_q[rd_addr];
    end
  end

  assign {rd_src, rd_id, rd_dest, rd_act, rd_new_id, rd_off, rd_len} = rd_word;

  AST_VALID_CLEAR_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0)) else $error("rule flags not cleared"); // R1
endmodule

// File: rtl/route_rule_match.sv
module route_rule_match
  import route_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                rule_valid,
  input  logic [CH_W-1:0]     rule_src,
  input  logic [CAN_ID_W-1:0] rule_id,
  input  logic [NUM_CH-1:0]   rule_dest,
  input  logic [CH_W-1:0]     frm_ch,
  input  logic [CAN_ID_W-1:0] frm_id,
  output logic                hit,
  output logic [NUM_CH-1:0]   out_mask
);
  assign hit = rule_valid && (rule_src == frm_ch) && (rule_id == frm_id);

  // echo suppression: never send back onto the arrival channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign out_mask[c] = rule_dest[c] && (frm_ch != CH_W'(c));
  end
endmodule

// File: rtl/route_merge_stage.sv
module route_merge_stage
  import route_pkg::*;
#(
  parameter int NUM_RULES  = 8,
  parameter int DATA_BYTES = 8,
  localparam int RI_W   = $clog2(NUM_RULES),
  localparam int OFF_W  = $clog2(DATA_BYTES),
  localparam int LEN_W  = $clog2(DATA_BYTES) + 1,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [RI_W-1:0]   cfg_addr,
  input  logic              cfg_is_merge,
  input  logic              upd,
  input  logic [RI_W-1:0]   upd_idx,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] stage_nx,
  output logic              complete
);
  logic [NUM_RULES-1:0] need_q;
  logic [NUM_RULES-1:0] have_q;
  logic [NUM_RULES-1:0] hot;

  assign hot      = NUM_RULES'(1) << upd_idx;
  assign complete = upd && (((have_q | hot) & need_q) == need_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      need_q <= '0;
      have_q <= '0;
    end else begin
      if (upd) have_q <= complete ? '0 : (have_q | hot);
      if (cfg_we) begin
        need_q[cfg_addr] <= cfg_is_merge;
        have_q[cfg_addr] <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    logic       in_rng;
    logic [7:0] nb;
    logic [7:0] q;
    int         rel;

    always_comb begin
      in_rng = (b >= int'(off)) && (b < int'(off) + int'(len));
      rel    = in_rng ? (b - int'(off)) : 0;
      nb     = 8'(din >> (8 * rel));
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (upd && in_rng) q <= nb;
    end

    assign stage_nx[8*b +: 8] = (upd && in_rng) ? nb : q;
  end

  AST_MERGE_TRACK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    complete |=> (have_q == '0)) else $error("merge record kept after send"); // R7
  AST_CFG_DROPS_CONTRIB: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !have_q[$past(cfg_addr)]) else $error("rewrite kept contribution"); // R11
endmodule

// File: rtl/rx_route_engine.sv
module rx_route_engine
  import route_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_RULES  = 8,
  parameter int DATA_BYTES = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int RI_W   = $clog2(NUM_RULES),
  localparam int OFF_W  = $clog2(DATA_BYTES),
  localparam int LEN_W  = $clog2(DATA_BYTES) + 1,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [RI_W-1:0]     cfg_addr,
  input  logic                cfg_valid,
  input  logic [CH_W-1:0]     cfg_src,
  input  logic [CAN_ID_W-1:0] cfg_id,
  input  logic [NUM_CH-1:0]   cfg_dest,
  input  logic [1:0]          cfg_act,
  input  logic [CAN_ID_W-1:0] cfg_new_id,
  input  logic [OFF_W-1:0]    cfg_off,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                rx_valid,
  input  logic [CH_W-1:0]     rx_ch,
  input  logic [CAN_ID_W-1:0] rx_id,
  input  logic [DATA_W-1:0]   rx_data,
  output logic                rx_busy,
  output logic                tx_valid,
  output logic [NUM_CH-1:0]   tx_mask,
  output logic [CAN_ID_W-1:0] tx_id,
  output logic [DATA_W-1:0]   tx_data
);
  localparam logic [RI_W-1:0] LAST_IDX = RI_W'(NUM_RULES - 1);

  scan_st_e            state;
  logic [RI_W-1:0]     issue_idx;
  logic                issue_on;
  logic                cmp_vld;
  logic [RI_W-1:0]     cmp_idx;
  logic [CH_W-1:0]     f_ch;
  logic [CAN_ID_W-1:0] f_id;
  logic [DATA_W-1:0]   f_data;

  logic                r_valid;
  logic [CH_W-1:0]     r_src;
  logic [CAN_ID_W-1:0] r_id;
  logic [NUM_CH-1:0]   r_dest;
  logic [1:0]          r_act;
  logic [CAN_ID_W-1:0] r_new_id;
  logic [OFF_W-1:0]    r_off;
  logic [LEN_W-1:0]    r_len;

  logic                hit;
  logic [NUM_CH-1:0]   eff_mask;
  logic                take;
  logic                merge_upd;
  logic                merge_done;
  logic [DATA_W-1:0]   merge_data;

  route_rule_table #(.NUM_CH(NUM_CH), .NUM_RULES(NUM_RULES), .DATA_BYTES(DATA_BYTES)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_valid(cfg_valid), .wr_src(cfg_src),
    .wr_id(cfg_id), .wr_dest(cfg_dest), .wr_act(cfg_act), .wr_new_id(cfg_new_id),
    .wr_off(cfg_off), .wr_len(cfg_len),
    .rd_addr(issue_idx),
    .rd_valid(r_valid), .rd_src(r_src), .rd_id(r_id), .rd_dest(r_dest),
    .rd_act(r_act), .rd_new_id(r_new_id), .rd_off(r_off), .rd_len(r_len)
  );

  route_rule_match #(.NUM_CH(NUM_CH)) u_match (
    .rule_valid(r_valid), .rule_src(r_src), .rule_id(r_id), .rule_dest(r_dest),
    .frm_ch(f_ch), .frm_id(f_id), .hit(hit), .out_mask(eff_mask)
  );

  assign take      = (state == ST_SCAN) && cmp_vld && hit;
  assign merge_upd = take && (r_act == ACT_MERGE);

  route_merge_stage #(.NUM_RULES(NUM_RULES), .DATA_BYTES(DATA_BYTES)) u_merge (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_is_merge(cfg_valid && (cfg_act == ACT_MERGE)),
    .upd(merge_upd), .upd_idx(cmp_idx), .off(r_off), .len(r_len),
    .din(f_data), .stage_nx(merge_data), .complete(merge_done)
  );

  assign rx_busy = (state == ST_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      issue_idx <= '0;
      issue_on  <= 1'b0;
      cmp_vld   <= 1'b0;
      cmp_idx   <= '0;
      f_ch      <= '0;
      f_id      <= '0;
      f_data    <= '0;
      tx_valid  <= 1'b0;
      tx_mask   <= '0;
      tx_id     <= '0;
      tx_data   <= '0;
    end else begin
      tx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rx_valid) begin
            f_ch      <= rx_ch;
            f_id      <= rx_id;
            f_data    <= rx_data;
            issue_idx <= '0;
            issue_on  <= 1'b1;
            cmp_vld   <= 1'b0;
            state     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          // one table read issued and one compared per cycle
          cmp_vld <= issue_on;
          cmp_idx <= issue_idx;
          if (issue_on) begin
            if (issue_idx == LAST_IDX) issue_on <= 1'b0;
            else issue_idx <= issue_idx + 1'b1;
          end
          if (cmp_vld && (hit || cmp_idx == LAST_IDX)) begin
            state    <= ST_IDLE;
            issue_on <= 1'b0;
            cmp_vld  <= 1'b0;
            if (hit) begin
              tx_mask <= eff_mask;
              case (r_act)
                ACT_COPY: begin
                  tx_valid <= |eff_mask;
                  tx_id    <= f_id;
                  tx_data  <= f_data;
                end
                ACT_XLAT: begin
                  tx_valid <= |eff_mask;
                  tx_id    <= r_new_id;
                  tx_data  <= f_data;
                end
                ACT_MERGE: begin
                  tx_valid <= merge_done && (|eff_mask);
                  tx_id    <= r_new_id;
                  tx_data  <= merge_data;
                end
                default: ;
              endcase
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // search length monitor for the latency bound
  logic [RI_W+1:0] scan_cnt;
  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) scan_cnt <= '0;
    else scan_cnt <= scan_cnt + 1'b1;
  end

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(scan_cnt) <= NUM_RULES + 1) else $error("search too long"); // R10
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid) else $error("transmit request longer than one cycle"); // R10
  AST_TX_NO_ECHO: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !tx_mask[f_ch]) else $error("frame echoed to arrival channel"); // R9
  AST_TX_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_mask != '0)) else $error("request with empty mask"); // R9
  AST_TX_AFTER_SEARCH: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(state == ST_SCAN)) else $error("request without search"); // R2
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN && $past(state == ST_SCAN)) |-> ($stable(f_id) && $stable(f_ch)))
    else $error("frame changed during search"); // R2
endmodule

// File: tb/rx_route_engine_bench.sv
module rx_route_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_src = '0;
  logic [10:0] cfg_id = '0;
  logic [3:0]  cfg_dest = '0;
  logic [1:0]  cfg_act = '0;
  logic [10:0] cfg_new_id = '0;
  logic [2:0]  cfg_off = '0;
  logic [3:0]  cfg_len = '0;
  logic        rx_valid = 1'b0;
  logic [1:0]  rx_ch = '0;
  logic [10:0] rx_id = '0;
  logic [63:0] rx_data = '0;
  logic        rx_busy;
  logic        tx_valid;
  logic [3:0]  tx_mask;
  logic [10:0] tx_id;
  logic [63:0] tx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_route_engine u_rx_route_engine (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid), .cfg_src(cfg_src),
    .cfg_id(cfg_id), .cfg_dest(cfg_dest), .cfg_act(cfg_act), .cfg_new_id(cfg_new_id),
    .cfg_off(cfg_off), .cfg_len(cfg_len),
    .rx_valid(rx_valid), .rx_ch(rx_ch), .rx_id(rx_id), .rx_data(rx_data),
    .rx_busy(rx_busy), .tx_valid(tx_valid), .tx_mask(tx_mask), .tx_id(tx_id), .tx_data(tx_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference table
  bit       m_valid [8];
  int       m_src [8];
  int       m_id [8];
  int       m_dest [8];
  int       m_act [8];
  int       m_new [8];
  int       m_off [8];
  int       m_len [8];
  bit       m_need [8];
  bit       m_have [8];
  bit [7:0] m_stage [8];

  // observed requests
  int          tx_cnt = 0;
  logic [3:0]  got_mask;
  logic [10:0] got_id;
  logic [63:0] got_data;

  always @(negedge clk) begin
    if (tx_valid) begin
      tx_cnt   <= tx_cnt + 1;
      got_mask <= tx_mask;
      got_id   <= tx_id;
      got_data <= tx_data;
    end
  end

  function automatic logic [63:0] pattern(int ch, int id);
    logic [63:0] d;
    for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'((ch * 37) + (id * 5) + (b * 19) + 1);
    return d;
  endfunction

  task automatic check(bit ok, string req, string what, logic [95:0] act_v, logic [95:0] exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic write_rule(int i, bit v, int src, int id, int dest, int act, int nid, int off, int len);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(i); cfg_valid = v; cfg_src = 2'(src); cfg_id = 11'(id);
    cfg_dest = 4'(dest); cfg_act = 2'(act); cfg_new_id = 11'(nid); cfg_off = 3'(off); cfg_len = 4'(len);
    @(negedge clk);
    cfg_we = 1'b0;
    m_valid[i] = v; m_src[i] = src; m_id[i] = id; m_dest[i] = dest; m_act[i] = act;
    m_new[i] = nid; m_off[i] = off; m_len[i] = len;
    m_need[i] = v && (act == 2); m_have[i] = 1'b0;
  endtask

  task automatic send(int ch, int id, bit intrude, string req);
    logic [63:0] d;
    logic [63:0] e_data;
    int e_n, e_mask, e_id, hitix;
    bit all;
    d = pattern(ch, id);
    e_n = 0; e_mask = 0; e_id = 0; e_data = '0; hitix = -1;
    for (int i = 0; i < 8; i++)
      if (hitix < 0 && m_valid[i] && m_src[i] == ch && m_id[i] == id) hitix = i;
    if (hitix >= 0) begin
      e_mask = m_dest[hitix] & ~(1 << ch) & 15;
      case (m_act[hitix])
        0: begin e_n = (e_mask != 0); e_id = id; e_data = d; end
        1: begin e_n = (e_mask != 0); e_id = m_new[hitix]; e_data = d; end
        2: begin
          for (int k = 0; k < m_len[hitix]; k++)
            if (m_off[hitix] + k < 8) m_stage[m_off[hitix] + k] = d[8*k +: 8];
          m_have[hitix] = 1'b1;
          all = 1'b1;
          for (int i = 0; i < 8; i++) if (m_need[i] && !m_have[i]) all = 1'b0;
          if (all) begin
            for (int i = 0; i < 8; i++) m_have[i] = 1'b0;
            e_n = (e_mask != 0);
            e_id = m_new[hitix];
            for (int b = 0; b < 8; b++) e_data[8*b +: 8] = m_stage[b];
          end
        end
        default: e_n = 0;
      endcase
    end
    @(negedge clk);
    tx_cnt = 0;
    rx_valid = 1'b1; rx_ch = 2'(ch); rx_id = 11'(id); rx_data = d;
    @(negedge clk);
    check(rx_busy === 1'b1, "R2", "busy after accept", 96'(rx_busy), 96'(1));
    if (intrude) begin
      rx_ch = 2'd0; rx_id = 11'h100; rx_data = pattern(0, 'h100);
      @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    while (rx_busy) @(negedge clk);
    @(negedge clk);
    check(tx_cnt == e_n, req, $sformatf("request count ch%0d id%0h", ch, id), 96'(tx_cnt), 96'(e_n));
    if (e_n == 1 && tx_cnt == 1) begin
      check(got_mask == 4'(e_mask), "R9", "destination mask", 96'(got_mask), 96'(e_mask));
      check(got_id == 11'(e_id), req, "identifier", 96'(got_id), 96'(e_id));
      check(got_data == e_data, req, "data", 96'(got_data), 96'(e_data));
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ids [7];
    ids = '{'h100, 'h155, 'h300, 'h301, 'h200, 'h7FF, 'h000};
    for (int i = 0; i < 8; i++) begin
      m_valid[i] = 0; m_need[i] = 0; m_have[i] = 0; m_stage[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rx_busy === 1'b0, "R1", "busy after reset", 96'(rx_busy), 96'(0));
    check(tx_valid === 1'b0, "R1", "tx_valid after reset", 96'(tx_valid), 96'(0));
    send(0, 'h100, 0, "R1");  // empty table: nothing matches

    write_rule(0, 1, 0, 'h100, 'hF, 0, 0, 0, 0);       // R5 copy, echo bit cleared
    write_rule(1, 1, 1, 'h100, 'h1, 1, 'h2AA, 0, 0);   // R6 translate
    write_rule(2, 1, 2, 'h155, 'h8, 3, 0, 0, 0);       // R8 block shadows next
    write_rule(3, 1, 2, 'h155, 'h8, 0, 0, 0, 0);       // R3 shadowed
    write_rule(4, 1, 0, 'h300, 'h4, 2, 'h7F0, 0, 3);   // R7 merge low
    write_rule(5, 1, 3, 'h301, 'h4, 2, 'h7F0, 3, 7);   // R7 merge high, clipped
    write_rule(6, 0, 1, 'h200, 'hF, 0, 0, 0, 0);       // R3 invalid entry
    write_rule(7, 1, 3, 'h7FF, 'h8, 0, 0, 0, 0);       // R9 only own channel

    for (int ch = 0; ch < 4; ch++)
      for (int k = 0; k < 7; k++)
        send(ch, ids[k], 0, "R3");

    send(0, 'h100, 0, "R5");
    send(1, 'h100, 0, "R6");
    send(2, 'h155, 0, "R8");
    send(2, 'h200, 0, "R4");
    send(3, 'h7FF, 0, "R9");
    send(3, 'h301, 0, "R7");
    send(3, 'h301, 0, "R7");
    send(0, 'h300, 0, "R7");
    send(1, 'h100, 1, "R2");

    write_rule(6, 1, 1, 'h200, 'hF, 0, 0, 0, 0);
    send(1, 'h200, 0, "R11");
    send(0, 'h300, 0, "R7");
    write_rule(4, 1, 0, 'h300, 'h4, 2, 'h7F0, 0, 3);
    send(3, 'h301, 0, "R11");
    send(0, 'h300, 0, "R11");
    write_rule(5, 0, 3, 'h301, 'h4, 2, 'h7F0, 3, 7);
    send(0, 'h300, 0, "R11");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule